// File: doc/BRIEF.md
# Segmented Address and Byte-Bank Selector

This block takes a logical address, made of a 16-bit segment base and a 16-bit offset, and turns it into a 20-bit physical byte address. It then plans the bus transfers to a 16-bit memory built from two byte-wide banks. The even bank sits on data lanes 7:0 and the odd bank on lanes 15:8. It accepts byte and word requests at any address. It drives the physical address, the bank selects (address bit 0 and an active-low high-bank enable) and lane-steered write data. For reads it returns the assembled result.

A word at an odd address crosses the bank boundary, so the block splits it into two single-byte transfers on consecutive cycles. It swaps the lanes for both transfers and joins the two read halves into one word. Each transfer occupies one cycle, and the memory answers on the read lanes in that same cycle. A new request is taken only while no transfer is pending.

Top module: `seg_bank_xfer`

## Requirements
- R1: The physical address of a request is (segment << 4) + offset, computed unsigned. It appears on `bus_addr` with `bus_valid` high in the cycle after the request is accepted.
- R2: A physical sum above 0xFFFFF wraps modulo 2^20. The second transfer of an odd word at 0xFFFFF goes to address 0x00000.
- R3: The bank code during a transfer is as follows. `bus_a0` equals `bus_addr[0]`. `bus_a0`=0 with `bus_hbe_n`=0 selects both banks. `bus_a0`=0 with `bus_hbe_n`=1 selects the even bank only. `bus_a0`=1 with `bus_hbe_n`=0 selects the odd bank only. `bus_a0`=1 with `bus_hbe_n`=1 never occurs.
- R4: A byte at an even address is one transfer with `bus_hbe_n`=1. On a write the byte is on lanes 7:0 and lanes 15:8 are zero. On a read `rd_data` is `{8'h00, bus_rdata[7:0]}`.
- R5: A byte at an odd address is one transfer with `bus_a0`=1 and `bus_hbe_n`=0. On a write the byte is on lanes 15:8 and lanes 7:0 are zero. On a read `rd_data` is `{8'h00, bus_rdata[15:8]}`.
- R6: A word at an even address is one transfer with `bus_hbe_n`=0. A write drives `wdata` unchanged. A read returns `bus_rdata` unchanged.
- R7: A word at an odd address is two transfers on back-to-back cycles. The first goes to the odd address with the odd bank only, carrying the low byte on lanes 15:8. The second goes to the address plus one with the even bank only, carrying the high byte on lanes 7:0. In both transfers the unused lane is zero.
- R8: An odd-word read returns `{second bus_rdata[7:0], first bus_rdata[15:8]}`. It is presented only after the second transfer.
- R9: `req_ready` is high exactly when no transfer is pending. A `req_valid` pulse while `req_ready` is low is ignored and causes no transfer.
- R10: `rd_valid` is a one-cycle pulse in the cycle after the last transfer of a read. A write never raises it.
- R11: After reset `bus_valid` and `rd_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_seg | input | 16 | Segment base |
| req_off | input | 16 | Offset within segment |
| req_wdata | input | 16 | Write data, byte in bits 7:0 for byte writes |
| req_ready | output | 1 | No transfer pending |
| bus_valid | output | 1 | A transfer occupies this cycle |
| bus_addr | output | 20 | Physical byte address of the transfer |
| bus_a0 | output | 1 | Address bit 0, low selects the even bank |
| bus_hbe_n | output | 1 | Active-low odd-bank enable |
| bus_we | output | 1 | Transfer is a write |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read lanes returned by memory in the transfer cycle |
| rd_valid | output | 1 | Read result valid, one cycle |
| rd_data | output | 16 | Assembled read result |

## Verification
The embedded properties watch every cycle for the legality of the bank code and for the second-transfer address being the first plus one, modulo 2^20. They also check that the second transfer uses only the even bank, that `req_ready` is low whenever the bus is busy, and that `rd_valid` only follows a bus cycle. Lane placement, zeroed unused lanes, the segment arithmetic with its wrap, and the reassembly of split reads depend on the data. Only the directed scenarios show those, by comparing against values computed from the requirements. The same holds for the dropping of a request made while busy.

// File: rtl/seg_bank_pkg.sv
package seg_bank_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  phys
);
  logic [PA_W-1:0] seg_sh;
  logic [PA_W-1:0] off_ext;

  always_comb begin
    seg_sh  = {seg, {SHIFT{1'b0}}};
    off_ext = PA_W'(off);
    // modulo 2^PA_W: carry out of the top bit is dropped
    phys    = seg_sh + off_ext;
  end
endmodule

// File: rtl/bank_plan.sv
module bank_plan #(
  parameter int PA_W   = 20,
  parameter int DATA_W = 16,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              is_word,
  input  logic              is_write,
  input  logic [PA_W-1:0]   phys,
  input  logic [DATA_W-1:0] wdata,
  output logic              first_hbe_n,
  output logic [DATA_W-1:0] first_lanes,
  output logic              need_second,
  output logic [PA_W-1:0]   second_addr,
  output logic [DATA_W-1:0] second_lanes
);
  logic [BYTE_W-1:0] lo_b;
  logic [BYTE_W-1:0] hi_b;
  logic              odd;

  always_comb begin
    lo_b         = wdata[BYTE_W-1:0];
    hi_b         = wdata[DATA_W-1:BYTE_W];
    odd          = phys[0];
    need_second  = is_word && odd;
    second_addr  = phys + PA_W'(1);
    second_lanes = '0;
    first_lanes  = '0;
    first_hbe_n  = 1'b1;
    if (is_word && !odd) begin
      first_hbe_n = 1'b0;
      first_lanes = wdata;
    end else if (odd) begin
      // odd bank only: the addressed byte rides the upper lanes
      first_hbe_n = 1'b0;
      first_lanes = {lo_b, {BYTE_W{1'b0}}};
      if (is_word) second_lanes = {{BYTE_W{1'b0}}, hi_b};
    end else begin
      first_lanes = {{BYTE_W{1'b0}}, lo_b};
    end
    if (!is_write) begin
      first_lanes  = '0;
      second_lanes = '0;
    end
  end
endmodule

// File: rtl/rd_merge.sv
module rd_merge
  import seg_bank_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BYTE_W = DATA_W / 2
) (
  input  phase_e            phase,
  input  logic              is_word,
  input  logic              is_odd,
  input  logic [DATA_W-1:0] rdata,
  input  logic [BYTE_W-1:0] lo_hold,
  output logic [DATA_W-1:0] result,
  output logic [BYTE_W-1:0] hold_next
);
  always_comb begin
    result    = '0;
    hold_next = lo_hold;
    unique case (phase)
      PH_FIRST: begin
        if (is_word && !is_odd)     result = rdata;
        else if (is_word && is_odd) hold_next = rdata[DATA_W-1:BYTE_W];
        else if (is_odd)            result = {{BYTE_W{1'b0}}, rdata[DATA_W-1:BYTE_W]};
        else                        result = {{BYTE_W{1'b0}}, rdata[BYTE_W-1:0]};
      end
      PH_SECOND: result = {rdata[BYTE_W-1:0], lo_hold};
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/seg_bank_xfer.sv
module seg_bank_xfer
  import seg_bank_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  localparam int PA_W   = SEG_W + SHIFT,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              bus_valid,
  output logic [PA_W-1:0]   bus_addr,
  output logic              bus_a0,
  output logic              bus_hbe_n,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [PA_W-1:0]   phys;
  logic              p_hbe_n, p_need2;
  logic [PA_W-1:0]   p_addr2;
  logic [DATA_W-1:0] p_lanes1, p_lanes2;

  seg_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_addr (
    .seg(req_seg), .off(req_off), .phys(phys)
  );

  bank_plan #(.PA_W(PA_W), .DATA_W(DATA_W)) u_plan (
    .is_word(req_word), .is_write(req_write), .phys(phys), .wdata(req_wdata),
    .first_hbe_n(p_hbe_n), .first_lanes(p_lanes1), .need_second(p_need2),
    .second_addr(p_addr2), .second_lanes(p_lanes2)
  );

  phase_e            phase_q, phase_d;
  logic [PA_W-1:0]   addr_q, addr_d, addr2_q, addr2_d;
  logic              hbe_n_q, hbe_n_d, we_q, we_d;
  logic              need2_q, need2_d, word_q, word_d, odd_q, odd_d;
  logic [DATA_W-1:0] lanes_q, lanes_d, lanes2_q, lanes2_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              rdv_q, rdv_d;
  logic [DATA_W-1:0] rdd_q, rdd_d;
  logic [DATA_W-1:0] merged;
  logic              accept, ld_en;

  rd_merge #(.DATA_W(DATA_W)) u_merge (
    .phase(phase_q), .is_word(word_q), .is_odd(odd_q), .rdata(bus_rdata),
    .lo_hold(lo_q), .result(merged), .hold_next(lo_d)
  );

  always_comb begin
    accept   = (phase_q == PH_IDLE) && req_valid;
    phase_d  = phase_q;
    addr_d   = addr_q;
    addr2_d  = addr2_q;
    hbe_n_d  = hbe_n_q;
    we_d     = we_q;
    need2_d  = need2_q;
    word_d   = word_q;
    odd_d    = odd_q;
    lanes_d  = lanes_q;
    lanes2_d = lanes2_q;
    rdd_d    = rdd_q;
    rdv_d    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d  = PH_FIRST;
          addr_d   = phys;
          addr2_d  = p_addr2;
          hbe_n_d  = p_hbe_n;
          we_d     = req_write;
          need2_d  = p_need2;
          word_d   = req_word;
          odd_d    = phys[0];
          lanes_d  = p_lanes1;
          lanes2_d = p_lanes2;
        end
      end
      PH_FIRST: begin
        if (need2_q) begin
          phase_d = PH_SECOND;
          addr_d  = addr2_q;
          hbe_n_d = 1'b1;
          lanes_d = lanes2_q;
        end else begin
          phase_d = PH_IDLE;
          rdv_d   = !we_q;
          if (!we_q) rdd_d = merged;
        end
      end
      PH_SECOND: begin
        phase_d = PH_IDLE;
        rdv_d   = !we_q;
        if (!we_q) rdd_d = merged;
      end
      default: phase_d = PH_IDLE;
    endcase
    ld_en = accept || (phase_q != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      phase_q  <= PH_IDLE;
      addr_q   <= '0;
      addr2_q  <= '0;
      hbe_n_q  <= 1'b1;
      we_q     <= 1'b0;
      need2_q  <= 1'b0;
      word_q   <= 1'b0;
      odd_q    <= 1'b0;
      lanes_q  <= '0;
      lanes2_q <= '0;
      lo_q     <= '0;
      rdv_q    <= 1'b0;
      rdd_q    <= '0;
    end else begin
      rdv_q <= rdv_d;
      if (ld_en) begin
        phase_q  <= phase_d;
        addr_q   <= addr_d;
        addr2_q  <= addr2_d;
        hbe_n_q  <= hbe_n_d;
        we_q     <= we_d;
        need2_q  <= need2_d;
        word_q   <= word_d;
        odd_q    <= odd_d;
        lanes_q  <= lanes_d;
        lanes2_q <= lanes2_d;
        lo_q     <= lo_d;
        rdd_q    <= rdd_d;
      end
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign bus_valid = (phase_q != PH_IDLE);
  assign bus_addr  = addr_q;
  assign bus_a0    = addr_q[0];
  assign bus_hbe_n = hbe_n_q;
  assign bus_we    = we_q;
  assign bus_wdata = lanes_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  // R3: a live transfer always enables at least one bank
  p_bank_live_r3: assert property (@(posedge clk) disable iff (!rst_q)
    bus_valid |-> !(bus_a0 && bus_hbe_n));

  // R7: second half of a split word goes to the even bank only
  p_second_even_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_q == PH_SECOND) |-> (!bus_a0 && bus_hbe_n));

  // R2: second address follows the first, wrapping at the top
  p_second_addr_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_q == PH_SECOND) |-> (bus_addr == PA_W'($past(bus_addr) + PA_W'(1))));

  // R9: no new request while the bus is busy
  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_q)
    bus_valid |-> !req_ready);

  // R10: a read result only follows a bus cycle and lasts one cycle
  p_rd_after_bus_r10: assert property (@(posedge clk) disable iff (!rst_q)
    rd_valid |-> ($past(bus_valid) && !$past(bus_we)));
  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_q)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/seg_bank_xfer_tb_top.sv
module seg_bank_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word;
  logic [15:0] req_seg, req_off, req_wdata;
  logic        req_ready, bus_valid, bus_a0, bus_hbe_n, bus_we, rd_valid;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata, rd_data;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  seg_bank_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_seg(req_seg), .req_off(req_off),
    .req_wdata(req_wdata), .req_ready(req_ready), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_a0(bus_a0), .bus_hbe_n(bus_hbe_n),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // memory stand-in: byte content is a function of its address
  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5A;
  endfunction
  assign bus_rdata = {mbyte({bus_addr[19:1], 1'b1}), mbyte({bus_addr[19:1], 1'b0})};

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    return 20'({s, 4'h0} + {4'h0, o});
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic wd, input logic [15:0] s,
                       input logic [15:0] o, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd;
    req_seg = s; req_off = o; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // single-transfer access; checks bus cycle and read result
  task automatic one_xfer(input string tag, input logic wr, input logic wd,
                          input logic [15:0] s, input logic [15:0] o,
                          input logic [15:0] d, input logic exp_hbe_n,
                          input logic [15:0] exp_lanes, input logic [15:0] exp_rd);
    logic [19:0] a;
    a = pa(s, o);
    issue(wr, wd, s, o, d);
    chk({tag, " valid"}, {31'b0, bus_valid}, 32'd1);
    chk({tag, " addr"}, {12'b0, bus_addr}, {12'b0, a});
    chk({tag, " bank"}, {30'b0, bus_a0, bus_hbe_n}, {30'b0, a[0], exp_hbe_n});
    chk({tag, " ready low"}, {31'b0, req_ready}, 32'd0);
    if (wr) chk({tag, " lanes"}, {16'b0, bus_wdata}, {16'b0, exp_lanes});
    @(negedge clk);
    chk({tag, " rd_valid"}, {31'b0, rd_valid}, {31'b0, !wr});
    if (!wr) chk({tag, " rd_data"}, {16'b0, rd_data}, {16'b0, exp_rd});
    chk({tag, " idle"}, {30'b0, bus_valid, req_ready}, 32'd1);
  endtask

  // odd-address word: two transfers
  task automatic split_word(input string tag, input logic wr, input logic [15:0] s,
                            input logic [15:0] o, input logic [15:0] d,
                            input logic poke_busy);
    logic [19:0] a, a2;
    a  = pa(s, o);
    a2 = 20'(a + 20'd1);
    issue(wr, 1'b1, s, o, d);
    chk({tag, " R7 first addr"}, {12'b0, bus_addr}, {12'b0, a});
    chk({tag, " R7 first bank"}, {30'b0, bus_a0, bus_hbe_n}, {30'b0, 2'b10});
    if (wr) chk({tag, " R7 first lanes"}, {16'b0, bus_wdata}, {16'b0, d[7:0], 8'h00});
    if (poke_busy) begin
      // R9: request while busy must be dropped
      req_valid = 1'b1; req_seg = 16'h1234; req_off = 16'h0000; req_word = 1'b0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 second addr"}, {12'b0, bus_addr}, {12'b0, a2});
    chk({tag, " R7 second bank"}, {30'b0, bus_a0, bus_hbe_n}, {30'b0, 2'b01});
    if (wr) chk({tag, " R7 second lanes"}, {16'b0, bus_wdata}, {16'b0, 8'h00, d[15:8]});
    chk({tag, " R10 no early rd"}, {31'b0, rd_valid}, 32'd0);
    @(negedge clk);
    chk({tag, " R10 rd_valid"}, {31'b0, rd_valid}, {31'b0, !wr});
    if (!wr) chk({tag, " R8 merged"}, {16'b0, rd_data}, {16'b0, mbyte(a2), mbyte(a)});
    chk({tag, " R9 idle"}, {30'b0, bus_valid, req_ready}, 32'd1);
    @(negedge clk);
    chk({tag, " R9 no stray xfer"}, {31'b0, bus_valid}, 32'd0);
    chk({tag, " R10 pulse"}, {31'b0, rd_valid}, 32'd0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [19:0] a;
    req_valid = 0; req_write = 0; req_word = 0;
    req_seg = 0; req_off = 0; req_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R11 reset", {29'b0, bus_valid, rd_valid, req_ready}, 32'd1);

    // R1 R6: even word read and write
    a = pa(16'h1000, 16'h0234);
    one_xfer("R1 R6 even word rd", 0, 1, 16'h1000, 16'h0234, 16'h0,
             1'b0, 16'h0, {mbyte(a | 20'd1), mbyte(a)});
    one_xfer("R6 even word wr", 1, 1, 16'hA0B0, 16'h0F02, 16'hBEEF,
             1'b0, 16'hBEEF, 16'h0);
    // R4: even byte
    a = pa(16'h0042, 16'h0010);
    one_xfer("R4 even byte rd", 0, 0, 16'h0042, 16'h0010, 16'h0,
             1'b1, 16'h0, {8'h00, mbyte(a)});
    one_xfer("R4 even byte wr", 1, 0, 16'h0042, 16'h0010, 16'hFF3C,
             1'b1, 16'h003C, 16'h0);
    // R5: odd byte
    a = pa(16'h7001, 16'h0005);
    one_xfer("R5 odd byte rd", 0, 0, 16'h7001, 16'h0005, 16'h0,
             1'b0, 16'h0, {8'h00, mbyte(a)});
    one_xfer("R5 odd byte wr", 1, 0, 16'h7001, 16'h0005, 16'h11A7,
             1'b0, 16'hA700, 16'h0);
    // R1 R2: wrap of the sum
    a = pa(16'hFFFF, 16'h0020);
    one_xfer("R2 wrap even word", 0, 1, 16'hFFFF, 16'h0020, 16'h0,
             1'b0, 16'h0, {mbyte(a | 20'd1), mbyte(a)});
    // R7 R8: split words
    split_word("odd word rd", 0, 16'h2345, 16'h0103, 16'h0, 1'b0);
    split_word("odd word wr", 1, 16'h0800, 16'h0777, 16'hC3D4, 1'b1);
    // R2: split at top of space wraps to 0
    split_word("odd word wrap", 0, 16'hF000, 16'hFFFF, 16'h0, 1'b1);
    split_word("odd word wrap wr", 1, 16'hFFFF, 16'h000F, 16'h9A81, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule